// File: doc/BRIEF.md
# Fine-Adjust Time-of-Day Counter

This block keeps a precision clock for packet timestamping. The time is held as a 48-bit seconds value and a nanoseconds value that stays in the range 0 to 999,999,999. A hidden 8-bit fraction counts in steps of 1/256 ns. On every clock the counter moves forward by a programmable step. The step has a whole-nanosecond part and a fractional part. Because the fraction is kept from cycle to cycle, a clock period that is not a whole number of nanoseconds can be tracked with no long-term drift.

Two requests can overwrite the running value. A load request sets the time to an absolute seconds and nanoseconds value. A correction request moves the time forward or backward by a signed seconds and nanoseconds offset. In any cycle the counter takes exactly one update: a load, a correction or the normal step. A capture pulse copies the current time into a snapshot register. The snapshot stays flagged as valid until the consumer acknowledges it.

Top module: `tod_counter`

## Requirements
- R1: After reset, the seconds, nanoseconds, fraction, snapshot and snapshot-valid flag are all zero. An acknowledge while no snapshot is valid leaves the flag at zero.
- R2: Each normal cycle adds `step_ns` nanoseconds plus `step_frac`/256 ns. When the 8-bit fraction overflows, one extra nanosecond is added. For example, a step of 5.3 ns is programmed as 0x05 and 0x4C, and a step of 0x00 and 0x80 adds one nanosecond every second cycle.
- R3: When the nanoseconds reach 1,000,000,000 or more, 1,000,000,000 is removed from them and one second is added.
- R4: Seconds are 48 bits wide. `now_sec_lo` carries bits 31:0 and `now_sec_hi` carries bits 47:32. The seconds value wraps modulo 2^48.
- R5: A load request sets the seconds and nanoseconds to the given values and clears the fraction. The load takes the place of that cycle's step. The loaded nanoseconds must be below 1,000,000,000.
- R6: A correction with `adj_sub`=0 adds the offset. If the nanoseconds overflow, one second is carried.
- R7: A correction with `adj_sub`=1 subtracts the offset. If the nanoseconds would go below zero, one second is borrowed and 1,000,000,000 is added to the nanoseconds. Seconds below zero wrap modulo 2^48.
- R8: When a load and a correction are requested in the same cycle, only the load takes effect.
- R9: A correction takes the place of that cycle's step: no step is added on that cycle. The correction leaves the fraction unchanged.
- R10: A capture pulse copies the seconds and nanoseconds shown on the outputs in the cycle it is sampled. The snapshot appears and `snap_valid` rises on the following cycle.
- R11: `snap_valid` stays high, and the snapshot stays unchanged, until an acknowledge is sampled. If a capture and an acknowledge arrive in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_ns | input | 8 | Whole-nanosecond step added each cycle |
| step_frac | input | 8 | Fractional step added each cycle, in units of 1/256 ns |
| set_req | input | 1 | Load request |
| set_sec | input | 48 | Seconds value to load |
| set_ns | input | 30 | Nanoseconds value to load |
| adj_req | input | 1 | Correction request |
| adj_sub | input | 1 | Correction sign: 0 adds, 1 subtracts |
| adj_sec | input | 48 | Seconds part of the correction offset |
| adj_ns | input | 30 | Nanoseconds part of the correction offset, below 1,000,000,000 |
| cap_pulse | input | 1 | Capture request |
| cap_ack | input | 1 | Acknowledge that clears the snapshot-valid flag |
| now_sec_lo | output | 32 | Current seconds, bits 31:0 |
| now_sec_hi | output | 16 | Current seconds, bits 47:32 |
| now_ns | output | 30 | Current nanoseconds |
| snap_sec_lo | output | 32 | Snapshot seconds, bits 31:0 |
| snap_sec_hi | output | 16 | Snapshot seconds, bits 47:32 |
| snap_ns | output | 30 | Snapshot nanoseconds |
| snap_valid | output | 1 | A snapshot is held and has not been acknowledged |

## Verification
Every result appears one clock after the edge that samples its request. This holds for a step, a load, a correction, a capture and an acknowledge alike. The bench drives each request on a falling edge. It pushes the expected time, snapshot and valid flag for the next rising edge into a queue, and the monitor pops and compares one entry a quarter period after each rising edge. The expected values come from a model that keeps the whole time as one count of 1/256 ns units modulo 2^48 seconds, so the carries, borrows and seconds wrap are computed independently of the design's split fields.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int SEC_W    = 48;
    localparam int SEC_LO_W = 32;
    localparam int SEC_HI_W = SEC_W - SEC_LO_W;
    localparam int NS_W     = 30;
    localparam int STEP_W   = 8;
    localparam int FRAC_W   = 8;
    localparam int NSX_W    = NS_W + 1;
    localparam logic [NSX_W-1:0] NS_PER_SEC = NSX_W'(1_000_000_000);

    // Running time including the sub-nanosecond fraction
    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } tod_t;

    // Timestamp as seen outside the block
    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } stamp_t;

    typedef struct packed {
        tod_t   now;
        stamp_t snap;
        logic   snap_v;
    } ctr_state_t;
endpackage

// File: rtl/tod_step.sv
module tod_step
    import tod_pkg::*;
(
    input  tod_t              cur,
    input  logic [STEP_W-1:0] whole,
    input  logic [FRAC_W-1:0] frac,
    output tod_t              nxt
);
    logic [FRAC_W:0]    frac_sum;
    logic [NSX_W-1:0]   ns_sum;
    logic [NSX_W-1:0]   ns_wrapped;
    logic               roll;

    always_comb begin
        frac_sum   = {1'b0, cur.frac} + {1'b0, frac};
        // fraction overflow contributes one extra nanosecond
        ns_sum     = {1'b0, cur.ns} + NSX_W'(whole) + NSX_W'(frac_sum[FRAC_W]);
        roll       = (ns_sum >= NS_PER_SEC);
        ns_wrapped = ns_sum - NS_PER_SEC;
        nxt.frac   = frac_sum[FRAC_W-1:0];
        nxt.ns     = roll ? ns_wrapped[NS_W-1:0] : ns_sum[NS_W-1:0];
        nxt.sec    = cur.sec + SEC_W'(roll);
    end
endmodule

// File: rtl/tod_adjust.sv
module tod_adjust
    import tod_pkg::*;
(
    input  tod_t   cur,
    input  logic   sub,
    input  stamp_t off,
    output tod_t   nxt
);
    logic [NSX_W-1:0] a_ns;
    logic [NSX_W-1:0] b_ns;
    logic [NSX_W-1:0] add_sum;
    logic [NSX_W-1:0] add_wrap;
    logic [NSX_W-1:0] sub_diff;
    logic             add_roll;
    logic             borrow;

    always_comb begin
        a_ns     = {1'b0, cur.ns};
        b_ns     = {1'b0, off.ns};
        add_sum  = a_ns + b_ns;
        add_wrap = add_sum - NS_PER_SEC;
        add_roll = (add_sum >= NS_PER_SEC);
        borrow   = (a_ns < b_ns);
        sub_diff = borrow ? (a_ns + NS_PER_SEC - b_ns) : (a_ns - b_ns);
        nxt.frac = cur.frac;
        if (sub) begin
            nxt.ns  = sub_diff[NS_W-1:0];
            nxt.sec = cur.sec - off.sec - SEC_W'(borrow);
        end else begin
            nxt.ns  = add_roll ? add_wrap[NS_W-1:0] : add_sum[NS_W-1:0];
            nxt.sec = cur.sec + off.sec + SEC_W'(add_roll);
        end
    end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STEP_W-1:0]   step_ns,
    input  logic [FRAC_W-1:0]   step_frac,
    input  logic                set_req,
    input  logic [SEC_W-1:0]    set_sec,
    input  logic [NS_W-1:0]     set_ns,
    input  logic                adj_req,
    input  logic                adj_sub,
    input  logic [SEC_W-1:0]    adj_sec,
    input  logic [NS_W-1:0]     adj_ns,
    input  logic                cap_pulse,
    input  logic                cap_ack,
    output logic [SEC_LO_W-1:0] now_sec_lo,
    output logic [SEC_HI_W-1:0] now_sec_hi,
    output logic [NS_W-1:0]     now_ns,
    output logic [SEC_LO_W-1:0] snap_sec_lo,
    output logic [SEC_HI_W-1:0] snap_sec_hi,
    output logic [NS_W-1:0]     snap_ns,
    output logic                snap_valid
);
    ctr_state_t st_d, st_q;
    tod_t       step_nxt;
    tod_t       adj_nxt;
    stamp_t     adj_off;

    assign adj_off = '{sec: adj_sec, ns: adj_ns};

    tod_step u_step (
        .cur   (st_q.now),
        .whole (step_ns),
        .frac  (step_frac),
        .nxt   (step_nxt)
    );

    tod_adjust u_adjust (
        .cur (st_q.now),
        .sub (adj_sub),
        .off (adj_off),
        .nxt (adj_nxt)
    );

    always_comb begin
        st_d = st_q;
        // exactly one time update per cycle: load, else correction, else step
        if (set_req) begin
            st_d.now = '{sec: set_sec, ns: set_ns, frac: '0};
        end else if (adj_req) begin
            st_d.now = adj_nxt;
        end else begin
            st_d.now = step_nxt;
        end
        if (cap_pulse) begin
            st_d.snap   = '{sec: st_q.now.sec, ns: st_q.now.ns};
            st_d.snap_v = 1'b1;
        end else if (cap_ack) begin
            st_d.snap_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign now_sec_lo  = st_q.now.sec[SEC_LO_W-1:0];
    assign now_sec_hi  = st_q.now.sec[SEC_W-1:SEC_LO_W];
    assign now_ns      = st_q.now.ns;
    assign snap_sec_lo = st_q.snap.sec[SEC_LO_W-1:0];
    assign snap_sec_hi = st_q.snap.sec[SEC_W-1:SEC_LO_W];
    assign snap_ns     = st_q.snap.ns;
    assign snap_valid  = st_q.snap_v;

    AST_NS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, now_ns} < NS_PER_SEC); // R3

    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_req && !adj_req && step_ns != '0) |=> (now_ns != $past(now_ns))); // R2

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && ({1'b0, set_ns} < NS_PER_SEC)) |=>
        (now_ns == $past(set_ns) && {now_sec_hi, now_sec_lo} == $past(set_sec))); // R8

    AST_CAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> (snap_valid && snap_ns == $past(now_ns)
                       && snap_sec_lo == $past(now_sec_lo))); // R10

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_valid && !cap_pulse && !cap_ack) |=> (snap_valid && $stable(snap_ns)
                                                    && $stable(snap_sec_lo))); // R11

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ack && !cap_pulse) |=> !snap_valid); // R11
endmodule

// File: tb/tod_counter_bench.sv
module tod_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  step_ns = '0;
    logic [7:0]  step_frac = '0;
    logic        set_req = 1'b0;
    logic [47:0] set_sec = '0;
    logic [29:0] set_ns = '0;
    logic        adj_req = 1'b0;
    logic        adj_sub = 1'b0;
    logic [47:0] adj_sec = '0;
    logic [29:0] adj_ns = '0;
    logic        cap_pulse = 1'b0;
    logic        cap_ack = 1'b0;
    logic [31:0] now_sec_lo, snap_sec_lo;
    logic [15:0] now_sec_hi, snap_sec_hi;
    logic [29:0] now_ns, snap_ns;
    logic        snap_valid;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tod_counter u_tod_counter (
        .clk(clk), .rst_n(rst_n), .step_ns(step_ns), .step_frac(step_frac),
        .set_req(set_req), .set_sec(set_sec), .set_ns(set_ns),
        .adj_req(adj_req), .adj_sub(adj_sub), .adj_sec(adj_sec), .adj_ns(adj_ns),
        .cap_pulse(cap_pulse), .cap_ack(cap_ack),
        .now_sec_lo(now_sec_lo), .now_sec_hi(now_sec_hi), .now_ns(now_ns),
        .snap_sec_lo(snap_sec_lo), .snap_sec_hi(snap_sec_hi), .snap_ns(snap_ns),
        .snap_valid(snap_valid)
    );

    // Reference: whole time as one count of 1/256 ns units, modulo 2^48 seconds
    localparam logic [127:0] SEC_UNITS = 128'd256_000_000_000;
    localparam logic [127:0] MODU      = SEC_UNITS << 48;

    typedef struct {
        logic [47:0] sec;
        logic [29:0] ns;
        logic [47:0] ssec;
        logic [29:0] sns;
        logic        sv;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [127:0] m_units = '0;
    logic [127:0] m_snap  = '0;
    logic         m_valid = 1'b0;

    function automatic logic [47:0] u_sec(input logic [127:0] u);
        logic [127:0] s;
        s = u / SEC_UNITS;
        return s[47:0];
    endfunction

    function automatic logic [29:0] u_ns(input logic [127:0] u);
        logic [127:0] r;
        r = (u % SEC_UNITS) >> 8;
        return r[29:0];
    endfunction

    // Driver: at a falling edge, predict the state after the next rising edge
    task automatic cycle(input string tag);
        logic [127:0] pre;
        logic [127:0] off;
        exp_t e;
        pre = m_units;
        if (set_req) begin
            m_units = {80'd0, set_sec} * SEC_UNITS + {98'd0, set_ns} * 128'd256;
        end else if (adj_req) begin
            off = {80'd0, adj_sec} * SEC_UNITS + {98'd0, adj_ns} * 128'd256;
            if (adj_sub) m_units = (m_units + MODU - off) % MODU;
            else         m_units = (m_units + off) % MODU;
        end else begin
            m_units = (m_units + {120'd0, step_ns} * 128'd256 + {120'd0, step_frac}) % MODU;
        end
        if (cap_pulse) begin
            m_snap  = pre;
            m_valid = 1'b1;
        end else if (cap_ack) begin
            m_valid = 1'b0;
        end
        e.sec  = u_sec(m_units);
        e.ns   = u_ns(m_units);
        e.ssec = u_sec(m_snap);
        e.sns  = u_ns(m_snap);
        e.sv   = m_valid;
        e.tag  = tag;
        sb.push_back(e);
        @(negedge clk);
        set_req   = 1'b0;
        adj_req   = 1'b0;
        cap_pulse = 1'b0;
        cap_ack   = 1'b0;
    endtask

    // Monitor: compare a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if ({now_sec_hi, now_sec_lo} !== e.sec || now_ns !== e.ns ||
                    {snap_sec_hi, snap_sec_lo} !== e.ssec || snap_ns !== e.sns ||
                    snap_valid !== e.sv) begin
                    n_fail++;
                    $display("FAIL %s: got sec=%0h ns=%0d snap=%0h/%0d v=%0b, expected sec=%0h ns=%0d snap=%0h/%0d v=%0b",
                             e.tag, {now_sec_hi, now_sec_lo}, now_ns,
                             {snap_sec_hi, snap_sec_lo}, snap_ns, snap_valid,
                             e.sec, e.ns, e.ssec, e.sns, e.sv);
                end
            end
        end
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        n_checks++;
        if ({now_sec_hi, now_sec_lo, now_ns} !== '0 || snap_valid !== 1'b0 ||
            {snap_sec_hi, snap_sec_lo, snap_ns} !== '0) begin
            n_fail++;
            $display("FAIL R1: got sec=%0h ns=%0d v=%0b, expected all zero",
                     {now_sec_hi, now_sec_lo}, now_ns, snap_valid);
        end
        // R1: ack without a snapshot has no effect
        cap_ack = 1'b1;
        cycle("R1 ack idle");

        // R2: 5.3 ns step
        step_ns = 8'h05; step_frac = 8'h4C;
        for (int i = 0; i < 12; i++) cycle("R2 step 5.3ns");
        // R2: half-nanosecond step, carry from fraction only
        step_ns = 8'h00; step_frac = 8'h80;
        for (int i = 0; i < 5; i++) cycle("R2 frac carry");

        // R5, R3, R4: load near second boundary and low/high seconds boundary
        step_ns = 8'd7; step_frac = 8'h00;
        set_req = 1'b1; set_sec = 48'h0000_FFFF_FFFF; set_ns = 30'd999_999_990;
        cycle("R5 load");
        for (int i = 0; i < 3; i++) cycle("R3 R4 ns wrap into sec hi");

        // R4: 48-bit seconds wrap to zero
        step_ns = 8'd10;
        set_req = 1'b1; set_sec = 48'hFFFF_FFFF_FFFF; set_ns = 30'd999_999_995;
        cycle("R5 load top");
        cycle("R4 sec wrap");
        cycle("R4 after wrap");

        // R6, R9: add with nanosecond carry, fraction kept
        step_ns = 8'd3; step_frac = 8'hC0;
        set_req = 1'b1; set_sec = 48'd100; set_ns = 30'd700_000_000;
        cycle("R5 load");
        cycle("R2 frac build");
        adj_req = 1'b1; adj_sub = 1'b0; adj_sec = 48'd3; adj_ns = 30'd600_000_000;
        cycle("R6 R9 add carry");
        cycle("R9 frac kept");
        adj_req = 1'b1; adj_sub = 1'b0; adj_sec = 48'd0; adj_ns = 30'd5;
        cycle("R6 add small");

        // R7: subtract with borrow
        adj_req = 1'b1; adj_sub = 1'b1; adj_sec = 48'd2; adj_ns = 30'd900_000_000;
        cycle("R7 sub borrow");
        adj_req = 1'b1; adj_sub = 1'b1; adj_sec = 48'd1; adj_ns = 30'd1;
        cycle("R7 sub plain");
        // R7: below zero wraps seconds
        set_req = 1'b1; set_sec = 48'd0; set_ns = 30'd100;
        cycle("R5 load");
        adj_req = 1'b1; adj_sub = 1'b1; adj_sec = 48'd0; adj_ns = 30'd200;
        cycle("R7 sub below zero");
        cycle("R7 after wrap");

        // R8: load beats correction
        set_req = 1'b1; set_sec = 48'h1234_5678_9ABC; set_ns = 30'd42;
        adj_req = 1'b1; adj_sub = 1'b0; adj_sec = 48'd9; adj_ns = 30'd9;
        cycle("R8 load wins");
        cycle("R8 after");

        // R10, R11: capture, hold, ack, capture with ack
        cap_pulse = 1'b1;
        cycle("R10 capture");
        for (int i = 0; i < 3; i++) cycle("R11 hold");
        cap_ack = 1'b1;
        cycle("R11 ack");
        cycle("R11 cleared");
        cap_pulse = 1'b1;
        cycle("R10 capture 2");
        cap_pulse = 1'b1; cap_ack = 1'b1;
        cycle("R11 capture beats ack");
        cycle("R11 hold 2");
        cap_pulse = 1'b1; adj_req = 1'b1; adj_sub = 1'b1; adj_sec = 48'd1; adj_ns = 30'd0;
        cycle("R10 capture with correction");
        cycle("R10 after");

        repeat (3) @(negedge clk);
        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R2: %0d results outstanding, expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule